// File: doc/BRIEF.md
# Dual-Mode Interrupt Controller Register Front End

This block sits between a processor's register-access path and the register file of a local interrupt controller. It accepts accesses in two address spaces. In legacy mode, requests carry a 16-byte-aligned byte offset. In extended mode, requests carry a register index. Both spaces land on the same internal storage. The block also holds the mode control register, which has an enable bit and an extended bit, and it refuses any mode change that is not allowed.

The command register is laid out differently in each mode. In legacy mode it is two 32-bit halves, and writing the low half launches the interrupt. In extended mode it is one 64-bit write. A launched command appears on a send port together with its destination. It stays there until the delivery fabric acknowledges it. While it waits, the legacy view reports it as pending.

Every request gets a registered response one cycle later. An access that is not legal in the current mode produces a one-cycle error flag, returns zero data and changes nothing.

Top module: `irqf_front`

## Requirements
- R1: After reset the block is enabled in legacy mode. The command low word and the destination are zero, nothing is pending, every scratch register is zero, and the destination-format register is all ones.
- R2: In legacy mode the slot is offset[11:4]. An offset with any of bits [3:0] set is illegal. Slots 0x08 to 0x0B are read/write scratch registers. Every request is answered with rsp_valid in the following cycle. Writes and unmapped slots answer with zero data and no error.
- R3: In extended mode the index is the slot plus 0x800. An index outside 0x800 to 0x8FF is illegal. A given slot reaches the same storage in both modes.
- R4: A request is illegal when the controller is disabled, or when req_ext differs from the current extended bit.
- R5: An illegal request raises rsp_err for exactly the one response cycle, returns zero data and modifies no state.
- R6: The destination-format register at slot 0x0E is reachable only in legacy mode. Its extended index 0x80E is illegal.
- R7: The ID register at slot 0x02 reads as {hw_id[7:0], 24'b0} in legacy mode and as hw_id in extended mode. Writes to it are ignored without an error.
- R8: In legacy mode, a write to slot 0x31 stores the destination from wdata[31:24], and reading slot 0x31 returns it in bits 31:24. A write to slot 0x30 launches a send. The send carries send_dest equal to the stored 8-bit destination and send_cmd equal to the written word with bit 12 cleared.
- R9: In extended mode, a write to slot 0x30 takes the destination from wdata[63:32] and the command from wdata[31:0], and launches a send. Reading slot 0x30 returns {destination, command} with bit 12 at zero. Index 0x831 is illegal.
- R10: A launched send holds send_valid with a stable payload until send_ack, and it clears in the cycle after the ack. A legacy read of slot 0x30 shows the pending state in bit 12. A command write that arrives while a send is pending and unacknowledged is illegal. If the ack arrives in the same cycle as the write, the write is legal.
- R11: The allowed mode moves, written as {enable, extended}, are: any state to itself except 01, 10 to 11, 10 to 00, 11 to 00, and 00 to 10. Any other mode write leaves the mode unchanged and raises mode_err for one cycle.
- R12: When a request and a mode write fall in the same cycle, the request is judged and answered under the mode that held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ext | input | 1 | 1 = extended index access, 0 = legacy offset access |
| req_addr | input | 12 | Byte offset (legacy) or register index (extended) |
| req_wdata | input | 64 | Write data; legacy uses bits 31:0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | The previous request was illegal |
| rsp_rdata | output | 64 | Read data; zero for writes and errors |
| mode_wr | input | 1 | Write the mode control register |
| mode_wr_en | input | 1 | Requested enable bit |
| mode_wr_ext | input | 1 | Requested extended bit |
| mode_en | output | 1 | Current enable bit |
| mode_ext | output | 1 | Current extended bit |
| mode_err | output | 1 | The previous mode write was refused |
| hw_id | input | 32 | Hardware-assigned controller ID |
| send_valid | output | 1 | A command is pending delivery |
| send_dest | output | 32 | Destination of the pending command |
| send_cmd | output | 32 | Command word of the pending command |
| send_ack | input | 1 | The delivery fabric accepted the command |

## Verification
Two functions of this block can act in the same cycle: a register request and a mode write. A similar overlap exists between a send acknowledge and a new command write. The bench provokes both on purpose. It issues a legacy read together with the legacy-to-extended switch, and a command write together with the acknowledge. The random phase then lets both overlaps occur freely. A bench model decides legality from the mode and pending state that held before the edge, then applies the mode change and the write. Each response and each send output is compared against that model.

// File: rtl/irqf_pkg.sv
// Package: shared slot numbers, register kinds and the mode-move rule.
// Assumes slots are 8 bits wide; the slot numbers below are the layout
// that both address spaces decode.
package irqf_pkg;

    localparam logic [7:0] SLOT_ID     = 8'h02;
    localparam logic [7:0] SLOT_DFMT   = 8'h0E;
    localparam logic [7:0] SLOT_CMD_LO = 8'h30;
    localparam logic [7:0] SLOT_CMD_HI = 8'h31;

    typedef enum logic [2:0] {
        K_NONE,
        K_ID,
        K_DFMT,
        K_CMD_LO,
        K_CMD_HI,
        K_SCR
    } reg_kind_e;

    // Returns 1 when moving from {cur_en,cur_ext} to {nx_en,nx_ext} is allowed.
    function automatic logic mode_move_ok(input logic cur_en, input logic cur_ext,
                                          input logic nx_en,  input logic nx_ext);
        logic ok;
        unique case ({cur_en, cur_ext})
            2'b10:   ok = !(!nx_en && nx_ext);
            2'b11:   ok = (nx_en && nx_ext) || (!nx_en && !nx_ext);
            default: ok = !nx_ext;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/irqf_decode.sv
// Module: irqf_decode
// Turns a request address into a slot and a register kind, and judges
// whether the access is legal. Legacy addresses are byte offsets (16-byte
// aligned); extended addresses are indices starting at EXT_BASE.
// Assumes ADDR_W - 4 >= SLOT_W. Purely combinational.
module irqf_decode
    import irqf_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                SLOT_W   = 8,
    parameter logic [ADDR_W-1:0] EXT_BASE = 12'h800,
    parameter logic [7:0]        SCR_SLOT = 8'h08,
    parameter int                N_SCR    = 4,
    localparam int               SCR_IW   = (N_SCR > 1) ? $clog2(N_SCR) : 1
) (
    input  logic              req_ext,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              mode_en,
    input  logic              mode_ext,
    input  logic              cmd_busy,
    output reg_kind_e         kind,
    output logic [SCR_IW-1:0] scr_idx,
    output logic              illegal
);

    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 ** SLOT_W);

    logic [SLOT_W-1:0] slot;
    logic              addr_bad;
    logic [ADDR_W-1:0] rel;

    // Slot extraction and range/alignment check for the active address space.
    always_comb begin
        rel = req_addr - EXT_BASE;
        if (req_ext) begin
            slot     = SLOT_W'(rel);
            addr_bad = (req_addr < EXT_BASE) || (rel >= SPAN);
        end else begin
            slot     = SLOT_W'(req_addr >> 4);
            addr_bad = (req_addr[3:0] != 4'h0);
        end
    end

    // Classify the slot into a register kind.
    always_comb begin
        scr_idx = SCR_IW'(slot - SLOT_W'(SCR_SLOT));
        if (slot == SLOT_W'(SLOT_ID))
            kind = K_ID;
        else if (slot == SLOT_W'(SLOT_DFMT))
            kind = K_DFMT;
        else if (slot == SLOT_W'(SLOT_CMD_LO))
            kind = K_CMD_LO;
        else if (slot == SLOT_W'(SLOT_CMD_HI))
            kind = K_CMD_HI;
        else if ((slot >= SLOT_W'(SCR_SLOT)) && (slot < SLOT_W'(SCR_SLOT) + SLOT_W'(N_SCR)))
            kind = K_SCR;
        else
            kind = K_NONE;
    end

    // Legality: mode gate, space match, address shape, mode-only registers, busy command.
    always_comb begin
        illegal = !mode_en
               || (req_ext != mode_ext)
               || addr_bad
               || (req_ext && (kind == K_DFMT || kind == K_CMD_HI))
               || (req_write && (kind == K_CMD_LO) && cmd_busy);
    end

endmodule

// File: rtl/irqf_mode.sv
// Module: irqf_mode
// Holds the enable and extended bits. It applies a mode write only when the
// move is allowed, and pulses err for one cycle otherwise.
// Assumes at most one mode write per cycle.
module irqf_mode
    import irqf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_en,
    input  logic wr_ext,
    output logic en_q,
    output logic ext_q,
    output logic err_q
);

    logic legal;

    // Judge the requested move against the present state.
    always_comb legal = mode_move_ok(en_q, ext_q, wr_en, wr_ext);

    // Mode state and the refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b1;
            ext_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            err_q <= wr && !legal;
            if (wr && legal) begin
                en_q  <= wr_en;
                ext_q <= wr_ext;
            end
        end
    end

    AST_EXT_NEVER_TO_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && ext_q) |=> !(en_q && !ext_q)); // R11
    AST_EXT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!en_q && ext_q)); // R11
    AST_REFUSED_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $stable({en_q, ext_q})); // R11

endmodule

// File: rtl/irqf_store.sv
// Module: irqf_store
// Scratch registers plus the destination-format register. Writes arrive
// already qualified as legal; the read port is a plain index.
// Assumes scr_idx < N_SCR whenever we_scr is high.
module irqf_store #(
    parameter int  N_SCR  = 4,
    localparam int SCR_IW = (N_SCR > 1) ? $clog2(N_SCR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_scr,
    input  logic [SCR_IW-1:0] scr_idx,
    input  logic              we_dfmt,
    input  logic [31:0]       wdata,
    output logic [31:0]       scr_rd,
    output logic [31:0]       dfmt_q
);

    logic [31:0] scr_all [N_SCR];

    for (genvar g = 0; g < N_SCR; g++) begin : g_scr
        logic [31:0] r_q;
        // One scratch register, written when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r_q <= '0;
            else if (we_scr && (scr_idx == SCR_IW'(g)))
                r_q <= wdata;
        end
        assign scr_all[g] = r_q;
    end

    // Destination-format register, reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dfmt_q <= '1;
        else if (we_dfmt)
            dfmt_q <= wdata;
    end

    // Scratch read selection.
    always_comb scr_rd = scr_all[scr_idx];

endmodule

// File: rtl/irqf_cmd.sv
// Module: irqf_cmd
// Command register in both layouts, plus the pending send. At launch it
// latches a send payload that stays fixed until the acknowledge.
// Assumes launch is asserted only when the command is not busy.
module irqf_cmd (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_mode,
    input  logic        hi_we,
    input  logic        launch,
    input  logic [63:0] wdata,
    input  logic        send_ack,
    output logic [31:0] lo_q,
    output logic [31:0] dest_q,
    output logic        pend_q,
    output logic        busy,
    output logic [31:0] sdest_q,
    output logic [31:0] scmd_q
);

    localparam logic [31:0] STATUS_MASK = 32'h0000_1000;

    logic [31:0] lo_next;

    // Command word with the status position cleared.
    always_comb lo_next = wdata[31:0] & ~STATUS_MASK;

    // Busy means pending and not released in this same cycle.
    always_comb busy = pend_q && !send_ack;

    // Programmed command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            dest_q <= '0;
        end else if (launch) begin
            lo_q <= lo_next;
            if (ext_mode)
                dest_q <= wdata[63:32];
        end else if (hi_we) begin
            dest_q <= {24'h0, wdata[31:24]};
        end
    end

    // Pending flag and the latched send payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            sdest_q <= '0;
            scmd_q  <= '0;
        end else if (launch) begin
            pend_q  <= 1'b1;
            sdest_q <= ext_mode ? wdata[63:32] : dest_q;
            scmd_q  <= lo_next;
        end else if (send_ack) begin
            pend_q <= 1'b0;
        end
    end

    AST_SEND_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !send_ack && !launch) |=> ($stable(sdest_q) && $stable(scmd_q) && pend_q)); // R10
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && send_ack && !launch) |=> !pend_q); // R10
    AST_LAUNCH_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (pend_q && !scmd_q[12])); // R8

endmodule

// File: rtl/irqf_front.sv
// Module: irqf_front (top)
// Register front end of a local interrupt controller with a legacy offset
// space and an extended index space over one register file. It answers
// every request one cycle later, refuses illegal ones, and runs the
// command register's send handshake.
// Assumes at most one request and at most one mode write per cycle.
module irqf_front
    import irqf_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                SLOT_W   = 8,
    parameter logic [ADDR_W-1:0] EXT_BASE = 12'h800,
    parameter logic [7:0]        SCR_SLOT = 8'h08,
    parameter int                N_SCR    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_ext,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    input  logic              mode_wr,
    input  logic              mode_wr_en,
    input  logic              mode_wr_ext,
    output logic              mode_en,
    output logic              mode_ext,
    output logic              mode_err,
    input  logic [31:0]       hw_id,
    output logic              send_valid,
    output logic [31:0]       send_dest,
    output logic [31:0]       send_cmd,
    input  logic              send_ack
);

    localparam int SCR_IW = (N_SCR > 1) ? $clog2(N_SCR) : 1;

    reg_kind_e         kind;
    logic [SCR_IW-1:0] scr_idx;
    logic              illegal;
    logic              wr_ok;
    logic              cmd_busy;
    logic [31:0]       cmd_lo;
    logic [31:0]       cmd_dest;
    logic              cmd_pend;
    logic [31:0]       scr_rd;
    logic [31:0]       dfmt;
    logic [63:0]       rd_mux;
    logic              rsp_valid_q;
    logic              rsp_err_q;
    logic [63:0]       rsp_rdata_q;

    irqf_decode #(
        .ADDR_W   (ADDR_W),
        .SLOT_W   (SLOT_W),
        .EXT_BASE (EXT_BASE),
        .SCR_SLOT (SCR_SLOT),
        .N_SCR    (N_SCR)
    ) u_decode (
        .req_ext   (req_ext),
        .req_write (req_write),
        .req_addr  (req_addr),
        .mode_en   (mode_en),
        .mode_ext  (mode_ext),
        .cmd_busy  (cmd_busy),
        .kind      (kind),
        .scr_idx   (scr_idx),
        .illegal   (illegal)
    );

    irqf_mode u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (mode_wr),
        .wr_en  (mode_wr_en),
        .wr_ext (mode_wr_ext),
        .en_q   (mode_en),
        .ext_q  (mode_ext),
        .err_q  (mode_err)
    );

    // Write qualification shared by all storage.
    always_comb wr_ok = req_valid && req_write && !illegal;

    irqf_store #(
        .N_SCR (N_SCR)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_scr  (wr_ok && (kind == K_SCR)),
        .scr_idx (scr_idx),
        .we_dfmt (wr_ok && (kind == K_DFMT)),
        .wdata   (req_wdata[31:0]),
        .scr_rd  (scr_rd),
        .dfmt_q  (dfmt)
    );

    irqf_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_mode (mode_ext),
        .hi_we    (wr_ok && (kind == K_CMD_HI)),
        .launch   (wr_ok && (kind == K_CMD_LO)),
        .wdata    (req_wdata),
        .send_ack (send_ack),
        .lo_q     (cmd_lo),
        .dest_q   (cmd_dest),
        .pend_q   (cmd_pend),
        .busy     (cmd_busy),
        .sdest_q  (send_dest),
        .scmd_q   (send_cmd)
    );

    // Read data by kind, shaped by the current mode.
    always_comb begin
        unique case (kind)
            K_ID:     rd_mux = mode_ext ? {32'h0, hw_id} : {32'h0, hw_id[7:0], 24'h0};
            K_DFMT:   rd_mux = {32'h0, dfmt};
            K_CMD_LO: rd_mux = mode_ext ? {cmd_dest, cmd_lo}
                                        : {32'h0, cmd_lo[31:13], cmd_pend, cmd_lo[11:0]};
            K_CMD_HI: rd_mux = {32'h0, cmd_dest[7:0], 24'h0};
            K_SCR:    rd_mux = {32'h0, scr_rd};
            default:  rd_mux = '0;
        endcase
    end

    // Registered response: valid, error and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_err_q   <= req_valid && illegal;
            rsp_rdata_q <= (req_valid && !illegal && !req_write) ? rd_mux : '0;
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_err    = rsp_err_q;
    assign rsp_rdata  = rsp_rdata_q;
    assign send_valid = cmd_pend;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_MISALIGNED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ext && (req_addr[3:0] != 4'h0)) |=> rsp_err); // R2
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && (rsp_rdata == 64'h0))); // R5
    AST_ERR_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_err); // R5
    AST_DFMT_EXT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ext && (req_addr == EXT_BASE + ADDR_W'(SLOT_DFMT))) |=> rsp_err); // R6
    AST_DISABLED_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_en) |=> rsp_err); // R4

endmodule

// File: tb/irqf_front_tb.sv
`timescale 1ns/1ps
module irqf_front_tb;

    localparam logic [31:0] HWID = 32'hA5B6_C7D8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_ext = 0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        mode_wr = 0, mode_wr_en = 0, mode_wr_ext = 0;
    logic        mode_en, mode_ext, mode_err;
    logic        send_valid;
    logic [31:0] send_dest, send_cmd;
    logic        send_ack = 0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench model state
    bit          m_en, m_ext, m_pend;
    logic [31:0] m_scr [4];
    logic [31:0] m_dfmt, m_lo, m_dest, m_sdest, m_scmd;

    always #2.5 clk = ~clk;

    irqf_front u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_ext(req_ext),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mode_wr(mode_wr), .mode_wr_en(mode_wr_en), .mode_wr_ext(mode_wr_ext),
        .mode_en(mode_en), .mode_ext(mode_ext), .mode_err(mode_err),
        .hw_id(HWID),
        .send_valid(send_valid), .send_dest(send_dest), .send_cmd(send_cmd),
        .send_ack(send_ack)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit move_ok(input bit ce, input bit cx, input bit ne, input bit nx);
        return ({ce, cx, ne, nx} == 4'b1010) || ({ce, cx, ne, nx} == 4'b1111) ||
               ({ce, cx, ne, nx} == 4'b0000) || ({ce, cx, ne, nx} == 4'b1011) ||
               ({ce, cx, ne, nx} == 4'b1000) || ({ce, cx, ne, nx} == 4'b1100) ||
               ({ce, cx, ne, nx} == 4'b0010);
    endfunction

    function automatic logic [63:0] read_val(input logic [7:0] slot);
        case (slot)
            8'h02: return m_ext ? {32'h0, HWID} : {32'h0, HWID[7:0], 24'h0};
            8'h0E: return {32'h0, m_dfmt};
            8'h30: return m_ext ? {m_dest, m_lo} : {32'h0, m_lo | (m_pend ? 32'h1000 : 32'h0)};
            8'h31: return {32'h0, m_dest[7:0], 24'h0};
            8'h08, 8'h09, 8'h0A, 8'h0B: return {32'h0, m_scr[slot - 8'h08]};
            default: return 64'h0;
        endcase
    endfunction

    // One cycle: drive at the falling edge, sample at the next falling edge.
    task automatic step(input string tag, input bit v, input bit w, input bit x,
                        input logic [11:0] a, input logic [63:0] wd,
                        input bit mw, input bit me, input bit mx, input bit ack);
        bit          ill, abad, busy, mok;
        logic [7:0]  slot;
        logic [63:0] erd;
        busy = m_pend && !ack;
        if (x) begin
            abad = (a < 12'h800) || (a > 12'h8FF);
            slot = a[7:0];
        end else begin
            abad = (a[3:0] != 4'h0);
            slot = a[11:4];
        end
        ill = !m_en || (x != m_ext) || abad || (x && (slot == 8'h0E || slot == 8'h31)) ||
              (w && slot == 8'h30 && busy);
        erd = (v && !w && !ill) ? read_val(slot) : 64'h0;
        mok = move_ok(m_en, m_ext, me, mx);
        req_valid = v; req_write = w; req_ext = x; req_addr = a; req_wdata = wd;
        mode_wr = mw; mode_wr_en = me; mode_wr_ext = mx; send_ack = ack;
        @(negedge clk);
        chk(tag, "rsp_valid", 64'(rsp_valid), 64'(v));
        chk(tag, "rsp_err", 64'(rsp_err), 64'(v && ill));
        chk(tag, "rsp_rdata", rsp_rdata, erd);
        chk(tag, "mode_err", 64'(mode_err), 64'(mw && !mok));
        // model update
        if (v && w && !ill) begin
            case (slot)
                8'h0E: m_dfmt = wd[31:0];
                8'h31: m_dest = {24'h0, wd[31:24]};
                8'h08, 8'h09, 8'h0A, 8'h0B: m_scr[slot - 8'h08] = wd[31:0];
                8'h30: begin
                    m_lo = wd[31:0] & ~32'h1000;
                    if (m_ext) m_dest = wd[63:32];
                    m_sdest = m_dest;
                    m_scmd = m_lo;
                end
                default: ;
            endcase
        end
        if (v && w && !ill && slot == 8'h30) m_pend = 1;
        else if (ack) m_pend = 0;
        if (mw && mok) begin m_en = me; m_ext = mx; end
        chk(tag, "mode", 64'({mode_en, mode_ext}), 64'({m_en, m_ext}));
        chk(tag, "send_valid", 64'(send_valid), 64'(m_pend));
        if (m_pend) begin
            chk(tag, "send_dest", 64'(send_dest), 64'(m_sdest));
            chk(tag, "send_cmd", 64'(send_cmd), 64'(m_scmd));
        end
        req_valid = 0; mode_wr = 0; send_ack = 0;
    endtask

    task automatic rd(input string tag, input bit x, input logic [11:0] a);
        step(tag, 1, 0, x, a, 64'h0, 0, 0, 0, 0);
    endtask
    task automatic wr(input string tag, input bit x, input logic [11:0] a, input logic [63:0] d);
        step(tag, 1, 1, x, a, d, 0, 0, 0, 0);
    endtask
    task automatic mset(input string tag, input bit e, input bit x);
        step(tag, 0, 0, 0, 12'h0, 64'h0, 1, e, x, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] slots [9];
        slots = '{8'h02, 8'h0E, 8'h30, 8'h31, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h05};
        void'($urandom(32'd2024));
        m_en = 1; m_ext = 0; m_pend = 0;
        foreach (m_scr[i]) m_scr[i] = '0;
        m_dfmt = '1; m_lo = '0; m_dest = '0; m_sdest = '0; m_scmd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "mode_en", 64'(mode_en), 64'd1);
        chk("R1", "mode_ext", 64'(mode_ext), 64'd0);
        chk("R1", "send_valid", 64'(send_valid), 64'd0);
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        rd("R1", 0, 12'h0E0);
        rd("R1", 0, 12'h080);
        rd("R1", 0, 12'h300);
        // R2 legacy scratch, misalignment, unmapped slot
        wr("R2", 0, 12'h090, 64'h1234_5678);
        rd("R2", 0, 12'h090);
        wr("R2", 0, 12'h0A4, 64'hDEAD);
        rd("R2", 0, 12'h0A0);
        rd("R2", 0, 12'h050);
        // R7 ID presentation and ignored write
        rd("R7", 0, 12'h020);
        wr("R7", 0, 12'h020, 64'hFFFF_FFFF);
        rd("R7", 0, 12'h020);
        // R6 legacy format register write
        wr("R6", 0, 12'h0E0, 64'h0F00_0000);
        rd("R6", 0, 12'h0E0);
        // R4 extended access while legacy
        rd("R4", 1, 12'h802);
        // R8 legacy command
        wr("R8", 0, 12'h310, 64'h5A00_0000);
        rd("R8", 0, 12'h310);
        wr("R8", 0, 12'h300, 64'h0000_10FE);
        // R10 pending: status bit, refused write, ack same cycle
        rd("R10", 0, 12'h300);
        wr("R10", 0, 12'h300, 64'h0000_00AA);
        step("R10", 1, 1, 0, 12'h300, 64'h0000_0BCD, 0, 0, 0, 1);
        rd("R10", 0, 12'h300);
        step("R10", 0, 0, 0, 12'h0, 64'h0, 0, 0, 0, 1);
        rd("R10", 0, 12'h300);
        // R12 request together with a move to extended
        step("R12", 1, 0, 0, 12'h090, 64'h0, 1, 1, 1, 0);
        rd("R12", 0, 12'h090);
        // R3 / R7 / R9 / R6 in extended mode
        rd("R3", 1, 12'h809);
        rd("R3", 1, 12'h900);
        rd("R3", 1, 12'h7F0);
        rd("R7", 1, 12'h802);
        rd("R6", 1, 12'h80E);
        wr("R9", 1, 12'h830, 64'h0000_0077_0000_1041);
        rd("R9", 1, 12'h830);
        wr("R9", 1, 12'h831, 64'h1);
        step("R9", 0, 0, 0, 12'h0, 64'h0, 0, 0, 0, 1);
        // R11 mode moves
        mset("R11", 1, 0);
        mset("R11", 0, 1);
        mset("R11", 0, 0);
        rd("R4", 0, 12'h090);
        rd("R5", 1, 12'h809);
        mset("R11", 1, 1);
        mset("R11", 1, 0);
        rd("R2", 0, 12'h090);
        // R5 illegal write drops data
        wr("R5", 0, 12'h098, 64'h9999);
        rd("R5", 0, 12'h090);
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit          v, w, x, mw, me, mx, ack;
            logic [7:0]  s;
            logic [11:0] a;
            v = ($urandom % 4) != 0;
            w = $urandom % 2;
            x = (($urandom % 10) == 0) ? !m_ext : m_ext;
            s = slots[$urandom % 9];
            if (x) a = (($urandom % 10) == 0) ? 12'h900 + 12'($urandom % 16) : 12'h800 + 12'(s);
            else   a = {s, (($urandom % 8) == 0) ? 4'($urandom % 16) : 4'h0};
            mw = ($urandom % 12) == 0;
            me = ($urandom % 4) != 0;
            mx = $urandom % 2;
            ack = ($urandom % 3) == 0;
            step((n % 2) ? "R10" : "R12", v, w, x, a, {$urandom, $urandom}, mw, me, mx, ack);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule